// File: doc/BRIEF.md
# Pipeline Forwarding and Interlock Unit

This block resolves data hazards for a five-stage in-order load-store integer pipeline (fetch, decode/register read, execute, memory, write-back). Every instruction writes the register file in the fifth stage, including register-type instructions, which pass through an idle memory stage. The register file therefore has only one write port, and two writes never meet there. A 32-entry register file is addressed by 5-bit indices.

Each cycle the unit looks at the source indices of the instructions in decode and execute, and at the destination indices and write-enables of the instructions in execute, memory and write-back. It also looks at a flag that marks a load in execute. From these it chooses where each ALU operand comes from, so that ALU results reach dependent instructions without delay. A loaded value cannot reach the instruction directly behind the load. For that case the unit freezes fetch and decode for one cycle and sends a bubble into execute. Once the load has reached write-back, its value is forwarded from there. A flush input squashes the front of the pipeline and takes precedence over any pending stall.

The unit is purely combinational. The clock and reset ports only sample the built-in checks.

Top module: `pipe_hazard_unit`

## Requirements
- R1: An operand select has three codes: 2'b00 takes the register file value, 2'b01 takes the memory-stage result and 2'b10 takes the write-back result. An execute source takes 2'b01 when the memory stage writes (`mem_we_i`=1) to the same nonzero index.
- R2: An execute source takes 2'b10 when the write-back stage writes to the same nonzero index and the memory stage does not.
- R3: When the memory and write-back stages both write the index of a source, the memory stage wins (2'b01).
- R4: Index 0 is never forwarded (select 2'b00), and a load with destination 0 never stalls.
- R5: A load-use hazard holds fetch and decode (`fd_hold_o`=1) and inserts a bubble into execute (`ex_bubble_o`=1). Such a hazard exists when execute holds a load (`ex_load_i`=1, `ex_we_i`=1) whose nonzero destination equals a decode source.
- R6: A non-load instruction in execute whose destination matches a decode source causes no stall, because its result is forwarded.
- R7: The two ALU operands are resolved independently, each from its own source index. A stall is raised when either decode source has a load-use hazard.
- R8: While `flush_i`=1, the unit drives `fd_clear_o`=1, `ex_bubble_o`=1 and `fd_hold_o`=0, even when a load-use hazard is present.
- R9: A stage whose write-enable is 0 neither forwards nor stalls, whatever its destination index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock for the built-in checks |
| rst_ni | input | 1 | Active-low asynchronous reset for the checks |
| id_rs1_i | input | 5 | First source index in decode |
| id_rs2_i | input | 5 | Second source index in decode |
| ex_rs1_i | input | 5 | First source index in execute |
| ex_rs2_i | input | 5 | Second source index in execute |
| ex_rd_i | input | 5 | Destination index in execute |
| ex_we_i | input | 1 | Execute instruction writes a register |
| ex_load_i | input | 1 | Execute instruction is a load |
| mem_rd_i | input | 5 | Destination index in memory stage |
| mem_we_i | input | 1 | Memory-stage instruction writes a register |
| wb_rd_i | input | 5 | Destination index in write-back |
| wb_we_i | input | 1 | Write-back instruction writes a register |
| flush_i | input | 1 | Squash fetch and decode |
| fwd_a_o | output | 2 | Operand A select (00 file, 01 memory, 10 write-back) |
| fwd_b_o | output | 2 | Operand B select (same codes) |
| fd_hold_o | output | 1 | Hold the fetch and decode registers |
| fd_clear_o | output | 1 | Clear the fetch and decode registers |
| ex_bubble_o | output | 1 | Load a no-op into the execute register |

## Verification
Directed patterns aim a single stage at one operand, then both stages at the same index, then disabled stages with matching indices. This separates the priority order from the write-enable gating. Loads are set against non-loads with the same destination, against each decode source in turn and against index 0, which shows whether the stall keys on the load flag, on both operands and on nonzero indices. A flush applied together with a live load hazard shows the override. A long run of pseudo-random patterns over a narrow index range then makes coincident matches frequent, so that combinations the directed cases miss are compared too.

// File: rtl/pipe_hazard_pkg.sv
package pipe_hazard_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_MEM = 2'b01,
    SRC_WB  = 2'b10
  } opnd_src_e;
endpackage

// File: rtl/hzd_operand_fwd.sv
module hzd_operand_fwd
  import pipe_hazard_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_we_i,
  input  logic [AW-1:0] wb_rd_i,
  input  logic          wb_we_i,
  output opnd_src_e     sel_o
);
  localparam int unsigned NSTG = 2;

  // index 0 = youngest stage (highest priority)
  logic      [NSTG-1:0][AW-1:0] stg_rd;
  logic      [NSTG-1:0]         stg_we;
  opnd_src_e [NSTG-1:0]         stg_code;
  logic                         src_live;

  assign stg_rd   = {wb_rd_i, mem_rd_i};
  assign stg_we   = {wb_we_i, mem_we_i};
  assign stg_code = {SRC_WB, SRC_MEM};
  assign src_live = |src_i;

  always_comb begin
    sel_o = SRC_RF;
    for (int k = NSTG - 1; k >= 0; k--) begin
      if (src_live && stg_we[k] && (stg_rd[k] == src_i)) sel_o = stg_code[k];
    end
  end

  p_zero_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == '0) |-> (sel_o == SRC_RF));
  p_mem_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i != '0 && mem_we_i && mem_rd_i == src_i) |-> (sel_o == SRC_MEM));
  p_wb_fwd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == SRC_WB) |-> (wb_we_i && wb_rd_i == src_i));
endmodule

// File: rtl/hzd_load_use.sv
module hzd_load_use #(
  parameter int unsigned AW      = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_SRC-1:0][AW-1:0] id_src_i,
  input  logic [AW-1:0]              ex_rd_i,
  input  logic                       ex_we_i,
  input  logic                       ex_load_i,
  output logic                       hazard_o
);
  logic [NUM_SRC-1:0] hit;
  logic               ld_live;

  assign ld_live = ex_load_i && ex_we_i && (ex_rd_i != '0);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign hit[g] = ld_live && (id_src_i[g] == ex_rd_i);
  end

  assign hazard_o = |hit;

  p_needs_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hazard_o |-> (ex_load_i && ex_we_i));
  p_no_zero_stall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_rd_i == '0) |-> !hazard_o);
endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
  import pipe_hazard_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] id_rs1_i,
  input  logic [AW-1:0] id_rs2_i,
  input  logic [AW-1:0] ex_rs1_i,
  input  logic [AW-1:0] ex_rs2_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_we_i,
  input  logic          ex_load_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_we_i,
  input  logic [AW-1:0] wb_rd_i,
  input  logic          wb_we_i,
  input  logic          flush_i,
  output logic [1:0]    fwd_a_o,
  output logic [1:0]    fwd_b_o,
  output logic          fd_hold_o,
  output logic          fd_clear_o,
  output logic          ex_bubble_o
);
  localparam int unsigned NUM_SRC = 2;

  logic      [NUM_SRC-1:0][AW-1:0] ex_src;
  logic      [NUM_SRC-1:0][AW-1:0] id_src;
  opnd_src_e [NUM_SRC-1:0]         sel;
  logic                            lu_hazard;

  assign ex_src = {ex_rs2_i, ex_rs1_i};
  assign id_src = {id_rs2_i, id_rs1_i};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_opnd
    hzd_operand_fwd #(.AW(AW)) u_fwd (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .src_i    (ex_src[g]),
      .mem_rd_i (mem_rd_i),
      .mem_we_i (mem_we_i),
      .wb_rd_i  (wb_rd_i),
      .wb_we_i  (wb_we_i),
      .sel_o    (sel[g])
    );
  end

  hzd_load_use #(.AW(AW), .NUM_SRC(NUM_SRC)) u_lu (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .id_src_i  (id_src),
    .ex_rd_i   (ex_rd_i),
    .ex_we_i   (ex_we_i),
    .ex_load_i (ex_load_i),
    .hazard_o  (lu_hazard)
  );

  assign fwd_a_o     = sel[0];
  assign fwd_b_o     = sel[1];
  // flush squashes decode, so its instruction must not enter execute either
  assign fd_hold_o   = lu_hazard && !flush_i;
  assign fd_clear_o  = flush_i;
  assign ex_bubble_o = lu_hazard || flush_i;

  p_flush_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> (!fd_hold_o && fd_clear_o && ex_bubble_o));
  p_hold_bubble_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fd_hold_o |-> ex_bubble_o);
  p_hold_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fd_hold_o |-> (ex_rd_i == id_rs1_i || ex_rd_i == id_rs2_i));
endmodule

// File: tb/pipe_hazard_unit_test.sv
module pipe_hazard_unit_test;
  localparam int unsigned AW = 5;
  localparam time TCK = 4ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rs1 = '0, ex_rs2 = '0;
  logic [AW-1:0] ex_rd = '0, mem_rd = '0, wb_rd = '0;
  logic          ex_we = 1'b0, ex_load = 1'b0, mem_we = 1'b0, wb_we = 1'b0, flush = 1'b0;
  logic [1:0]    fwd_a, fwd_b;
  logic          hold, clr, bub;

  int checks = 0;
  int errors = 0;

  always #(TCK / 2) clk = ~clk;

  pipe_hazard_unit #(.AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .id_rs1_i(id_rs1), .id_rs2_i(id_rs2), .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2),
    .ex_rd_i(ex_rd), .ex_we_i(ex_we), .ex_load_i(ex_load),
    .mem_rd_i(mem_rd), .mem_we_i(mem_we), .wb_rd_i(wb_rd), .wb_we_i(wb_we),
    .flush_i(flush),
    .fwd_a_o(fwd_a), .fwd_b_o(fwd_b), .fd_hold_o(hold), .fd_clear_o(clr),
    .ex_bubble_o(bub)
  );

  // reference: walk producers oldest to youngest, last hit wins
  function automatic logic [1:0] model_sel(logic [AW-1:0] s);
    logic [1:0] r = 2'b00;
    if (s == 0) return 2'b00;
    if (wb_we && wb_rd == s) r = 2'b10;
    if (mem_we && mem_rd == s) r = 2'b01;
    return r;
  endfunction

  function automatic logic model_stall();
    bit ld = ex_load && ex_we && ex_rd != 0;
    return ld && (id_rs1 == ex_rd || id_rs2 == ex_rd);
  endfunction

  task automatic check(string tag);
    logic [6:0] exp, act;
    logic st = model_stall();
    exp = {model_sel(ex_rs1), model_sel(ex_rs2), st && !flush, flush, st || flush};
    act = {fwd_a, fwd_b, hold, clr, bub};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {a,b,hold,clr,bub} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic idle();
    id_rs1 = 0; id_rs2 = 0; ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0; mem_rd = 0; wb_rd = 0;
    ex_we = 0; ex_load = 0; mem_we = 0; wb_we = 0; flush = 0;
  endtask

  // drive after the rising edge, compare on the falling edge
  task automatic step(string tag);
    @(negedge clk);
    check(tag);
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(TCK * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lfsr = 32'hACE1_1234;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    step("R4 reset/idle state");

    idle(); ex_rs1 = 5; mem_rd = 5; mem_we = 1; step("R1 memory forward A");
    idle(); ex_rs2 = 7; wb_rd = 7; wb_we = 1; step("R2 write-back forward B");
    idle(); ex_rs1 = 9; mem_rd = 9; mem_we = 1; wb_rd = 9; wb_we = 1; step("R3 memory over write-back");
    idle(); ex_rs1 = 6; mem_rd = 6; mem_we = 0; wb_rd = 6; wb_we = 1; step("R9 disabled memory stage");
    idle(); ex_rs1 = 6; ex_rs2 = 6; mem_rd = 6; wb_rd = 6; ex_rd = 6; ex_load = 1; id_rs1 = 6;
    step("R9 all write-enables low");
    idle(); mem_rd = 0; mem_we = 1; wb_rd = 0; wb_we = 1; step("R4 index zero not forwarded");
    idle(); ex_rd = 4; ex_we = 1; ex_load = 1; id_rs1 = 4; step("R5 load-use on source 1");
    idle(); ex_rd = 4; ex_we = 1; ex_load = 1; id_rs2 = 4; id_rs1 = 3; step("R7 load-use on source 2");
    idle(); ex_rd = 4; ex_we = 1; ex_load = 0; id_rs1 = 4; id_rs2 = 4; step("R6 ALU result no stall");
    idle(); ex_rd = 0; ex_we = 1; ex_load = 1; step("R4 load to index zero");
    idle(); ex_rd = 8; ex_we = 1; ex_load = 1; id_rs1 = 8; flush = 1; step("R8 flush overrides stall");
    idle(); flush = 1; step("R8 flush alone");
    idle(); ex_rs1 = 3; ex_rs2 = 12; mem_rd = 3; mem_we = 1; wb_rd = 12; wb_we = 1;
    step("R7 independent operands");

    for (int n = 0; n < 2000; n++) begin
      string tag;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      id_rs1 = 5'(lfsr[1:0]);   id_rs2 = 5'(lfsr[3:2]);
      ex_rs1 = 5'(lfsr[5:4]);   ex_rs2 = 5'(lfsr[7:6]);
      ex_rd  = 5'(lfsr[9:8]);   mem_rd = 5'(lfsr[11:10]); wb_rd = 5'(lfsr[13:12]);
      ex_we  = lfsr[14]; ex_load = lfsr[15]; mem_we = lfsr[16]; wb_we = lfsr[17];
      flush  = (lfsr[20:18] == 3'b000);
      if (flush) tag = "R8 random";
      else if (model_stall()) tag = "R5 random";
      else if (model_sel(ex_rs1) == 2'b01 || model_sel(ex_rs2) == 2'b01) tag = "R1 random";
      else if (model_sel(ex_rs1) == 2'b10 || model_sel(ex_rs2) == 2'b10) tag = "R2 random";
      else tag = "R9 random";
      step(tag);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule